// File: doc/BRIEF.md
# Power sequencing and reset controller

This block supervises a two-rail power-management device. It takes comparator flags for USB power, wall power, the maximum supply having reached battery level, rail 1 power-good at 90 %, and a fault indication. It also takes three user controls: two master turn-on inputs and a rail 2 request. From these it drives the rail 1, rail 2 and charger enables, and an active-low microcontroller reset.

Either source of external power is a turn-on cause on its own and forces rail 1 and the charger on. Without external power, either master control turns the device on. A rail is enabled only after the maximum supply reaches battery level. Rail 2 follows rail 1 and needs the rail 2 request and rail 1 power-good. The reset output is held low for a programmable interval after each turn-on, for as long as the device is off, and while a fault is flagged. Every input passes through a two-flop synchroniser, so it takes effect three clock edges after it changes.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While USB or wall power is present and no fault is flagged, rail 1 and the charger are enabled whatever the state of the two master controls. Wall power alone is sufficient.
- R2: Without external power, a high level on either master control turns rail 1 on. When both controls are low, all enables go low.
- R3: Rail 1 stays disabled while the max-supply-at-battery-level flag is low, even when a turn-on cause is present.
- R4: Rail 2 is enabled only while the rail 2 request is high, rail 1 is enabled and rail 1 power-good is high.
- R5: Loss of rail 1 power-good turns rail 2 off within the synchroniser latency. Rail 2 returns once power-good is back, and rail 1 stays on throughout.
- R6: The reset output rises exactly RST_CYCLES clock cycles after the rising edge of the rail 1 enable, provided power-good is already high. RST_CYCLES is CLK_HZ/1000*RST_MS.
- R7: The reset output is low out of reset and whenever the device is off.
- R8: A fault flag drives the reset output low and all enables low. The device stays off until the fault has cleared and a turn-on cause is present.
- R9: The charger enable is low whenever no external power is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| usb_ok_i | input | 1 | USB power present |
| wall_ok_i | input | 1 | Wall power present |
| vmax_ok_i | input | 1 | Max supply has reached battery level |
| rail1_pg_i | input | 1 | Rail 1 at or above 90 % of target |
| fault_i | input | 1 | Fault flag |
| on_i | input | 1 | Master turn-on control A |
| pwron_i | input | 1 | Master turn-on control B |
| on2_i | input | 1 | Rail 2 request |
| rail1_en_o | output | 1 | Rail 1 enable |
| rail2_en_o | output | 1 | Rail 2 enable |
| chg_en_o | output | 1 | Charger enable |
| mcu_rst_no | output | 1 | Microcontroller reset, active low |

## Verification
A wrong sequencer state shows up at the enables within three or four cycles of the stimulus that should have moved it. Examples are a rail enabled before the supply flag, a missing rail 2 cutoff, or a device left running after a fault. A wrong reset timer shows up as a release one or more cycles away from the exact count after the rail 1 enable rises. The bench measures that count to the cycle. An exit from the fault state that should not happen appears as rail 1 rising while no turn-on cause is present.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_WAIT_VMAX = 3'd1,
    ST_RAIL1_UP  = 3'd2,
    ST_RUN       = 3'd3,
    ST_FAULT     = 3'd4
  } seq_state_e;
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int unsigned CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);

  // R6
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && run_i) |=> done_o);
  // R6
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !done_o);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_i,
  input  logic       user_on_i,
  input  logic       vmax_i,
  input  logic       pg_i,
  input  logic       fault_i,
  input  logic       on2_i,
  input  logic       tmr_done_i,
  output logic       tmr_run_o,
  output logic       rail1_en_o,
  output logic       rail2_en_o,
  output logic       chg_en_o,
  output logic       mcu_rst_no
);
  seq_state_e state_q, state_d;
  logic cause;

  assign cause = ext_i | user_on_i;

  always_comb begin
    state_d = state_q;
    if (fault_i) state_d = ST_FAULT;
    else begin
      unique case (state_q)
        ST_OFF:       if (cause) state_d = ST_WAIT_VMAX;
        ST_WAIT_VMAX: if (!cause) state_d = ST_OFF;
                      else if (vmax_i) state_d = ST_RAIL1_UP;
        ST_RAIL1_UP:  if (!cause) state_d = ST_OFF;
                      else if (pg_i) state_d = ST_RUN;
        ST_RUN:       if (!cause) state_d = ST_OFF;
        ST_FAULT:     if (cause) state_d = ST_WAIT_VMAX;
        default:      state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign rail1_en_o = (state_q == ST_RAIL1_UP) || (state_q == ST_RUN);
  assign tmr_run_o  = rail1_en_o;
  // pg drop cuts rail 2 combinationally
  assign rail2_en_o = (state_q == ST_RUN) && on2_i && pg_i;
  assign chg_en_o   = ext_i && (state_q != ST_OFF) && (state_q != ST_FAULT);
  assign mcu_rst_no = (state_q == ST_RUN) && tmr_done_i && !fault_i;

  // R3
  vmax_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rail1_en_o) |-> $past(vmax_i));
  // R8
  fault_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fault_i) && fault_i |-> !rail1_en_o && !rail2_en_o && !chg_en_o && !mcu_rst_no);
  // R8
  fault_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FAULT) && !cause |=> !rail1_en_o);
  // R7
  off_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF) |-> !mcu_rst_no);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int unsigned CLK_HZ = 250_000_000,
  parameter int unsigned RST_MS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic usb_ok_i,
  input  logic wall_ok_i,
  input  logic vmax_ok_i,
  input  logic rail1_pg_i,
  input  logic fault_i,
  input  logic on_i,
  input  logic pwron_i,
  input  logic on2_i,
  output logic rail1_en_o,
  output logic rail2_en_o,
  output logic chg_en_o,
  output logic mcu_rst_no
);
  localparam int unsigned RST_CYCLES = (CLK_HZ / 1000) * RST_MS;
  localparam int NIN = 8;

  logic [NIN-1:0] raw, syn;
  logic usb_s, wall_s, vmax_s, pg_s, fault_s, on_s, pwron_s, on2_s;
  logic tmr_run, tmr_done;

  assign raw = {usb_ok_i, wall_ok_i, vmax_ok_i, rail1_pg_i,
                fault_i, on_i, pwron_i, on2_i};

  pwr_seq_sync #(.W(NIN)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  assign {usb_s, wall_s, vmax_s, pg_s, fault_s, on_s, pwron_s, on2_s} = syn;

  pwr_seq_timer #(.CYCLES(RST_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(tmr_run), .done_o(tmr_done)
  );

  pwr_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_i      (usb_s | wall_s),
    .user_on_i  (on_s | pwron_s),
    .vmax_i     (vmax_s),
    .pg_i       (pg_s),
    .fault_i    (fault_s),
    .on2_i      (on2_s),
    .tmr_done_i (tmr_done),
    .tmr_run_o  (tmr_run),
    .rail1_en_o (rail1_en_o),
    .rail2_en_o (rail2_en_o),
    .chg_en_o   (chg_en_o),
    .mcu_rst_no (mcu_rst_no)
  );

  // R4
  rail2_dep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rail2_en_o |-> rail1_en_o && pg_s && on2_s);
  // R9
  chg_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(usb_s || wall_s) |-> !chg_en_o);
  // R6
  rst_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mcu_rst_no) |-> rail1_en_o && $past(rail1_en_o));
endmodule

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
  localparam int unsigned CLK_HZ = 1000;
  localparam int unsigned RST_MS = 200;
  localparam int unsigned N = (CLK_HZ / 1000) * RST_MS;

  logic clk = 0, rst_ni = 0;
  logic usb = 0, wall = 0, vmax = 0, pg = 0, fault = 0, on = 0, pwron = 0, on2 = 0;
  logic rail1, rail2, chg, mrst_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  pwr_seq_ctrl #(.CLK_HZ(CLK_HZ), .RST_MS(RST_MS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .usb_ok_i(usb), .wall_ok_i(wall),
    .vmax_ok_i(vmax), .rail1_pg_i(pg), .fault_i(fault), .on_i(on),
    .pwron_i(pwron), .on2_i(on2), .rail1_en_o(rail1), .rail2_en_o(rail2),
    .chg_en_o(chg), .mcu_rst_no(mrst_n)
  );

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {rail1,rail2,chg,rst_n} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [3:0] outs();
    return {rail1, rail2, chg, mrst_n};
  endfunction

  task automatic t_reset();
    settle(1);
    chk("R7 reset state", outs(), 4'b0000);
  endtask

  task automatic t_vmax_and_timer();
    int k;
    pg = 1; on = 1; vmax = 0;
    settle(10);
    chk("R3 no rail before vmax", outs(), 4'b0000);
    vmax = 1;
    k = 0;
    while (!rail1 && k < 20) begin @(negedge clk); k++; end
    chk("R2 on turns rail1 on", {rail1, 3'b0}, 4'b1000);
    k = 0;
    while (!mrst_n && k < N + 20) begin @(negedge clk); k++; end
    checks++;
    if (k != N) begin
      errors++;
      $display("FAIL R6 reset interval: actual=%0d expected=%0d", k, N);
    end
    chk("R9 R4 no charger, no rail2", outs(), 4'b1001);
  endtask

  task automatic t_rail2();
    on2 = 1; settle(5);
    chk("R4 rail2 on", outs(), 4'b1101);
    pg = 0; settle(4);
    chk("R5 pg loss drops rail2", outs(), 4'b1001);
    pg = 1; settle(4);
    chk("R5 pg return restores rail2", outs(), 4'b1101);
    on2 = 0; settle(4);
    chk("R4 on2 low drops rail2", outs(), 4'b1001);
  endtask

  task automatic t_shutdown();
    on = 0; settle(5);
    chk("R7 shutdown all low", outs(), 4'b0000);
    pwron = 1; settle(6);
    chk("R2 pwron turns on, reset held", outs(), 4'b1000);
    pwron = 0; settle(5);
    chk("R2 both controls low", outs(), 4'b0000);
  endtask

  task automatic t_ext();
    usb = 1; settle(6);
    chk("R1 usb forces rail1 and charger", outs(), 4'b1010);
    wall = 1; settle(2); usb = 0; settle(5);
    chk("R1 wall alone keeps on", outs(), 4'b1010);
    settle(N);
    chk("R1 R6 released after interval", outs(), 4'b1011);
    wall = 0; settle(5);
    chk("R9 ext removed charger off", outs(), 4'b0000);
  endtask

  task automatic t_fault();
    on = 1; settle(N + 10);
    chk("R8 running before fault", outs(), 4'b1001);
    fault = 1; settle(4);
    chk("R8 fault forces all low", outs(), 4'b0000);
    on = 0; settle(3); fault = 0; settle(8);
    chk("R8 no cause stays off", outs(), 4'b0000);
    on = 1; settle(6);
    chk("R8 restart after clear", outs(), 4'b1000);
    on = 0; settle(5);
  endtask

  initial begin
    fork
      begin
        settle(3); rst_ni = 1;
        t_reset();
        t_vmax_and_timer();
        t_rail2();
        t_shutdown();
        t_ext();
        t_fault();
        done = 1;
      end
      begin
        settle(20000);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual=timeout expected=completion");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule